// File: doc/BRIEF.md
# Dual 64-bit Prescaled Alarm Timer

This block holds two identical general-purpose timers. Each one divides the system clock by a 16-bit prescale value and steps a 64-bit counter up or down on every resulting tick. A 64-bit compare value can raise an alarm once per arming. At the alarm the counter may optionally be reloaded in hardware from a 64-bit load register. Software never sees the live counter directly. It writes a strobe that freezes the count into a pair of 32-bit read registers, and it changes the counter only through a separate reload strobe.

Both timers share one interrupt enable register, one status register and one clear register. A single level interrupt output is high while any enabled status bit is set. All access goes through a simple word-addressed register port: writes take effect on the clock edge, and reads are combinational from the address.

Top module: `tmr64_pair`

## Requirements
- R1: After reset every register reads 0, both counters are 0 and `irq` is low.
- R2: Timer t owns addresses t*16+k. Control (k=0) holds the divider in bits [15:0], run in bit 16, up in bit 17, auto-reload in bit 18 and alarm arm in bit 19. A running timer ticks once every D clocks for divider D from 1 to 65535, and a divider of 0 means 65536. Any write to the control register restarts the prescaler phase.
- R3: On a tick the counter increments when up is 1 and decrements when up is 0, and it wraps modulo 2^64.
- R4: While run is 0 the counter holds its value.
- R5: The load words (k=1 low, k=2 high) do not touch the counter. A write with bit 0 set to k=3 copies them into the counter at that edge and restarts the prescaler phase.
- R6: A write with bit 0 set to k=4 latches the counter value present before that edge into the snapshot words (k=5 low, k=6 high). These stay unchanged until the next such write while the counter keeps running.
- R7: The alarm words (k=7 low, k=8 high) read back as written.
- R8: An alarm fires on a tick where arm is 1 and the counter equals the alarm value. It sets the timer's status bit once and clears arm, so no further alarm occurs until software sets arm again.
- R9: On an alarm with auto-reload 1 the counter takes the load value. With auto-reload 0 it steps normally.
- R10: Shared registers: enable at 0x80, status at 0x81 (read) and clear at 0x82 (write 1 to clear). Bit t belongs to timer t. `irq` is high exactly while some status bit and its enable bit are both 1. A disabled bit still records status.
- R11: A reload strobe in the same cycle as an auto-reload alarm leaves the counter at the load value once, and the status bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following: an alarm sets its status bit and drops arm, a status bit rises only after an alarm, and a paused counter with no reload strobe stays still. Only the bench scenarios can show that the tick count matches the divider, including the 65536 case and the restart of the prescaler phase. The same holds for the value reached after an auto-reload, the wrap when counting down, snapshot stability, masking of the interrupt, and the collision of a reload strobe with an auto-reload alarm.

// File: rtl/tmr64_pair.sv
module tmr64_pair #(
  parameter int NT = 2,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int CW    = 2 * DW;
  localparam int OFF_W = 4;
  localparam int TW    = AW - 1 - OFF_W;

  logic [OFF_W-1:0] off;
  logic [TW-1:0]    tsel;
  logic             shared_sel;
  assign off        = addr[OFF_W-1:0];
  assign tsel       = addr[AW-2:OFF_W];
  assign shared_sel = addr[AW-1];

  logic [NT-1:0]    fire, ctrl_wr, ld_stb, run_v, arm_v;
  logic [NT*CW-1:0] cnt_all;
  logic [DW-1:0]    rd_t [NT];
  logic [NT-1:0]    ien_q, ist_q, clr;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [PW-1:0] div_q, pre_q;
    logic          run_q, up_q, ar_q, arm_q, tick, hit, snap_stb;
    logic [CW-1:0] cnt_q, load_q, alarm_q, snap_q;
    logic [PW:0]   div_eff;

    assign hit      = wr_en && !shared_sel && (tsel == TW'(t));
    assign ctrl_wr[t] = hit && off == 4'd0;
    assign ld_stb[t]  = hit && off == 4'd3 && wr_data[0];
    assign snap_stb   = hit && off == 4'd4 && wr_data[0];
    assign div_eff    = (div_q == '0) ? {1'b1, {PW{1'b0}}} : {1'b0, div_q};
    assign tick       = run_q && ({1'b0, pre_q} == div_eff - (PW+1)'(1));
    assign fire[t]    = tick && arm_q && (cnt_q == alarm_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        {arm_q, ar_q, up_q, run_q} <= '0;
        div_q   <= '0;
        pre_q   <= '0;
        cnt_q   <= '0;
        load_q  <= '0;
        alarm_q <= '0;
        snap_q  <= '0;
      end else begin
        if (ctrl_wr[t]) {arm_q, ar_q, up_q, run_q, div_q} <= wr_data[PW+3:0];
        else if (fire[t]) arm_q <= 1'b0;

        if (ctrl_wr[t] || ld_stb[t]) pre_q <= '0;
        else if (run_q) pre_q <= tick ? '0 : pre_q + PW'(1);

        if (hit && off == 4'd1) load_q[DW-1:0]  <= wr_data;
        if (hit && off == 4'd2) load_q[CW-1:DW] <= wr_data;
        if (hit && off == 4'd7) alarm_q[DW-1:0]  <= wr_data;
        if (hit && off == 4'd8) alarm_q[CW-1:DW] <= wr_data;

        if (ld_stb[t] || (fire[t] && ar_q)) cnt_q <= load_q;
        else if (tick) cnt_q <= up_q ? cnt_q + CW'(1) : cnt_q - CW'(1);

        if (snap_stb) snap_q <= cnt_q;
      end
    end

    always_comb begin
      case (off)
        4'd0:    rd_t[t] = DW'({arm_q, ar_q, up_q, run_q, div_q});
        4'd1:    rd_t[t] = load_q[DW-1:0];
        4'd2:    rd_t[t] = load_q[CW-1:DW];
        4'd5:    rd_t[t] = snap_q[DW-1:0];
        4'd6:    rd_t[t] = snap_q[CW-1:DW];
        4'd7:    rd_t[t] = alarm_q[DW-1:0];
        4'd8:    rd_t[t] = alarm_q[CW-1:DW];
        default: rd_t[t] = '0;
      endcase
    end

    assign run_v[t] = run_q;
    assign arm_v[t] = arm_q;
    assign cnt_all[t*CW +: CW] = cnt_q;
  end

  logic shared_wr;
  assign shared_wr = wr_en && shared_sel && (tsel == '0);
  assign clr = (shared_wr && off == 4'd2) ? wr_data[NT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      if (shared_wr && off == 4'd0) ien_q <= wr_data[NT-1:0];
      ist_q <= (ist_q & ~clr) | fire;
    end
  end

  assign irq = |(ist_q & ien_q);

  always_comb begin
    rd_data = '0;
    if (shared_sel) begin
      if (tsel == '0 && off == 4'd0) rd_data = DW'(ien_q);
      if (tsel == '0 && off == 4'd1) rd_data = DW'(ist_q);
    end else begin
      for (int t = 0; t < NT; t++)
        if (tsel == TW'(t)) rd_data = rd_t[t];
    end
  end
endmodule

// File: rtl/tmr64_pair_chk.sv
module tmr64_pair_chk #(
  parameter int NT = 2,
  parameter int CW = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NT-1:0]    fire,
  input logic [NT-1:0]    ctrl_wr,
  input logic [NT-1:0]    ld_stb,
  input logic [NT-1:0]    run_v,
  input logic [NT-1:0]    arm_v,
  input logic [NT-1:0]    ist_q,
  input logic [NT*CW-1:0] cnt_all
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    assert_fire_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire[t] |=> ist_q[t]);
    assert_fire_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire[t] && !ctrl_wr[t] |=> !arm_v[t]);
    assert_paused_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[t] && !ld_stb[t] |=> $stable(cnt_all[t*CW +: CW]));
    assert_status_from_alarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ist_q[t]) |-> $past(fire[t]));
  end
endmodule

bind tmr64_pair tmr64_pair_chk #(.NT(NT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .ctrl_wr(ctrl_wr), .ld_stb(ld_stb),
  .run_v(run_v), .arm_v(arm_v), .ist_q(ist_q), .cnt_all(cnt_all)
);

// File: tb/tmr64_pair_bench.sv
`timescale 1ns/1ps
module tmr64_pair_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        irq;

  tmr64_pair u_tmr64_pair (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  longint cyc = 0, t_wr = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] q_exp [$];
  int          q_kind [$];
  string       q_tag [$];

  localparam logic [7:0] IEN = 8'h80, IST = 8'h81, ICLR = 8'h82;

  function automatic logic [7:0] ra(int t, int k);
    return 8'(t * 16 + k);
  endfunction

  function automatic logic [31:0] ctl(int dv, bit run, bit up, bit ar, bit arm);
    return {12'b0, arm, ar, up, run, 16'(dv)};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); t_wr = cyc;
    #1 wr_en = 0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a;
    q_exp.push_back(e); q_kind.push_back(0); q_tag.push_back(tag);
  endtask

  task automatic exp_irq(input bit e, input string tag);
    @(negedge clk);
    q_exp.push_back({31'b0, e}); q_kind.push_back(1); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic snap(input int t);
    wr(ra(t, 4), 32'd1);
  endtask

  task automatic load64(input int t, input logic [63:0] v);
    wr(ra(t, 1), v[31:0]); wr(ra(t, 2), v[63:32]); wr(ra(t, 3), 32'd1);
  endtask

  task automatic alarm64(input int t, input logic [63:0] v);
    wr(ra(t, 7), v[31:0]); wr(ra(t, 8), v[63:32]);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (q_exp.size() > 0) begin
        logic [31:0] e, act;
        int k;
        string tag;
        e = q_exp.pop_front(); k = q_kind.pop_front(); tag = q_tag.pop_front();
        act = (k == 1) ? {31'b0, irq} : rd_data;
        total++;
        if (act !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint t0, t1, n;
    logic [63:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    exp_rd(ra(0, 0), 32'd0, "R1 control after reset");
    exp_rd(ra(0, 5), 32'd0, "R1 snapshot after reset");
    exp_rd(IST, 32'd0, "R1 status after reset");
    exp_irq(0, "R1 irq after reset");

    wr(ra(0, 1), 32'h10); wr(ra(0, 2), 32'h1); snap(0);
    exp_rd(ra(0, 5), 32'd0, "R5 load words without strobe");
    wr(ra(0, 3), 32'd1); snap(0);
    exp_rd(ra(0, 5), 32'h10, "R5 reload strobe low");
    exp_rd(ra(0, 6), 32'h1, "R5 reload strobe high");

    wr(ra(0, 0), ctl(1, 1, 1, 0, 0)); t0 = t_wr; idle(9);
    wr(ra(0, 0), ctl(1, 0, 1, 0, 0)); n = t_wr - t0; snap(0);
    exp_rd(ra(0, 5), 32'(64'h10 + n), "R3 count up divide 1");
    idle(20); snap(0);
    exp_rd(ra(0, 5), 32'(64'h10 + n), "R4 paused count held");

    load64(0, 64'd2);
    wr(ra(0, 0), ctl(1, 1, 0, 0, 0)); t0 = t_wr; idle(4);
    wr(ra(0, 0), ctl(1, 0, 0, 0, 0)); n = t_wr - t0; snap(0);
    v = 64'd2 - 64'(n);
    exp_rd(ra(0, 5), v[31:0], "R3 count down wrap low");
    exp_rd(ra(0, 6), v[63:32], "R3 count down wrap high");

    load64(0, 64'd0);
    wr(ra(0, 0), ctl(4, 1, 1, 0, 0)); t0 = t_wr; idle(11);
    wr(ra(0, 0), ctl(4, 0, 1, 0, 0)); n = t_wr - t0; snap(0);
    exp_rd(ra(0, 5), 32'(n / 4), "R2 divide by 4");

    load64(0, 64'd0);
    wr(ra(0, 0), ctl(4, 1, 1, 0, 0)); idle(1);
    wr(ra(0, 0), ctl(4, 1, 1, 0, 0)); idle(2);
    wr(ra(0, 0), ctl(4, 0, 1, 0, 0)); snap(0);
    exp_rd(ra(0, 5), 32'd0, "R2 control write restarts prescaler");

    load64(0, 64'd0);
    wr(ra(0, 0), ctl(0, 1, 1, 0, 0)); t0 = t_wr; idle(65534);
    wr(ra(0, 0), ctl(0, 0, 1, 0, 0)); n = t_wr - t0; snap(0);
    exp_rd(ra(0, 5), 32'(n / 65536), "R2 divider 0 means 65536");

    load64(0, 64'd0);
    wr(ra(0, 0), ctl(1, 1, 1, 0, 0)); t0 = t_wr; idle(2);
    snap(0); n = t_wr - t0 - 1;
    exp_rd(ra(0, 5), 32'(n), "R6 snapshot value");
    idle(10);
    exp_rd(ra(0, 5), 32'(n), "R6 snapshot stable while running");
    wr(ra(0, 0), ctl(1, 0, 1, 0, 0));

    alarm64(1, 64'h01234567_DEADBEEF);
    exp_rd(ra(1, 7), 32'hDEADBEEF, "R7 alarm low readback");
    exp_rd(ra(1, 8), 32'h01234567, "R7 alarm high readback");

    wr(IEN, 32'd1);
    load64(0, 64'd0); alarm64(0, 64'd5);
    wr(ra(0, 0), ctl(1, 1, 1, 0, 1)); t0 = t_wr; idle(9);
    exp_rd(ra(0, 0), ctl(1, 1, 1, 0, 0), "R8 arm cleared by alarm");
    exp_rd(IST, 32'd1, "R8 status set by alarm");
    exp_irq(1, "R10 irq with enabled status");
    wr(ra(0, 0), ctl(1, 0, 1, 0, 0)); n = t_wr - t0; snap(0);
    exp_rd(ra(0, 5), 32'(n), "R9 no auto-reload keeps counting");
    wr(ICLR, 32'd1); idle(3);
    exp_rd(IST, 32'd0, "R8 single status event");
    exp_irq(0, "R10 irq after clear");

    load64(1, 64'd0); alarm64(1, 64'd3);
    wr(ra(1, 0), ctl(1, 1, 1, 0, 1)); idle(10);
    exp_rd(IST, 32'd2, "R10 status bit 1 while disabled");
    exp_irq(0, "R10 masked status");
    wr(IEN, 32'd3);
    exp_irq(1, "R10 enabled after status");
    wr(ICLR, 32'd2);
    exp_rd(IST, 32'd0, "R10 clear bit 1");
    exp_irq(0, "R10 irq low after clear");
    wr(ra(1, 0), ctl(1, 0, 1, 0, 0));

    load64(0, 64'd100); alarm64(0, 64'd103);
    wr(ra(0, 0), ctl(1, 1, 1, 1, 1)); t0 = t_wr; idle(9);
    wr(ra(0, 0), ctl(1, 0, 1, 1, 0)); n = t_wr - t0; snap(0);
    exp_rd(ra(0, 5), 32'(100 + n - 4), "R9 auto-reload at alarm");
    exp_rd(IST, 32'd1, "R9 status on auto-reload alarm");
    wr(ICLR, 32'd1);

    load64(0, 64'd50); alarm64(0, 64'd50);
    wr(ra(0, 0), ctl(1, 1, 1, 1, 1));
    wr(ra(0, 3), 32'd1); t1 = t_wr; idle(5);
    exp_rd(ra(0, 0), ctl(1, 1, 1, 1, 0), "R11 arm cleared on collision");
    wr(ra(0, 0), ctl(1, 0, 1, 1, 0)); n = t_wr - t1; snap(0);
    exp_rd(ra(0, 5), 32'(50 + n), "R11 single load on collision");
    exp_rd(IST, 32'd1, "R11 status still set");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule